// File: doc/BRIEF.md
# Lockable Output Source Selector

This block drives a 32-bit output word in which every bit is taken from one of two places: a pass-through data input bit, or one of eight pattern-generator lanes. A per-bit select register picks the source. Output bit i uses pattern lane i mod 8, so the eight lanes are replicated across the four bytes of the output.

Software reaches three registers through a small synchronous register bus with address, write strobe, write data and read data. The select register can be frozen by a guard bit held in a guard register. That guard bit can in turn be frozen by a seal bit held in a seal register. A seal bit can only be set, and stays set until reset, so one write can fix the routing until the next system reset.

Top module: `sigsel_lockable`

## Requirements
- R1: After reset the select, guard and seal registers all read 0 and the output equals the data input.
- R2: Output bit i equals data_in[i] when select bit i is 0, and pat_in[i mod 8] when select bit i is 1, combinationally.
- R3: A write to word offset 0x0 while guard bit 0 is 0 loads all 32 select bits at that clock edge. While guard bit 0 is 1 the write is ignored.
- R4: Guard bits 0 and 1 at offset 0xC are read/write. Guard bits 31..2 read 0 and ignore writes.
- R5: Seal bits 0 and 1 at offset 0xE are set by writing 1. Writing 0 has no effect, and a set bit stays 1 until reset. Seal bits 31..2 read 0.
- R6: While seal bit 0 is 1, writes to guard bit 0 are ignored. While seal bit 1 is 1, writes to guard bit 1 are ignored. Each guard bit stays independently writable while its own seal bit is 0.
- R7: A write is judged against the guard and seal values held before that write's clock edge.
- R8: Writes to any other offset change no register. Reads of those offsets return 0.
- R9: Reads of the select, guard and seal offsets return the current contents whatever the protection state. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_addr | input | 4 | Word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| data_in | input | 32 | Pass-through data bits |
| pat_in | input | 8 | Pattern-generator lanes |
| sel_out | output | 32 | Muxed output word |

## Verification
On every cycle the assertions check these properties: the per-bit output mux, that seal bits never clear, that a guarded select register or a sealed guard bit holds across a write, and that reserved read bits stay zero. The bench's scenarios are needed for the rest. These are the reset values, the exact timing of an accepted write, the ordering case in which a write to the seal register and a later guard write meet the old protection state, and reads of unused offsets after writes to them.

// File: rtl/sigsel_pkg.sv
package sigsel_pkg;
   localparam int unsigned ADDR_W   = 4;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned LANES    = 8;
   localparam int unsigned PROT_W   = 2;
   localparam logic [ADDR_W-1:0] OFF_SEL   = 4'h0;
   localparam logic [ADDR_W-1:0] OFF_GUARD = 4'hC;
   localparam logic [ADDR_W-1:0] OFF_SEAL  = 4'hE;

   typedef struct packed {
      logic sel;
      logic guard;
      logic seal;
   } wr_hit_t;
endpackage

// File: rtl/sigsel_decode.sv
module sigsel_decode
   import sigsel_pkg::*;
#(
   parameter int unsigned AW = ADDR_W
) (
   input  logic [AW-1:0] addr,
   input  logic          we,
   output wr_hit_t       hit
);
   initial assert (AW >= 4) else $error("address too narrow for offsets");

   always_comb begin
      hit.sel   = we && (addr == OFF_SEL[AW-1:0]);
      hit.guard = we && (addr == OFF_GUARD[AW-1:0]);
      hit.seal  = we && (addr == OFF_SEAL[AW-1:0]);
   end
endmodule

// File: rtl/sigsel_protect.sv
module sigsel_protect #(
   parameter int unsigned PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          guard_wr,
   input  logic          seal_wr,
   input  logic [PW-1:0] wdata,
   output logic [PW-1:0] guard_q,
   output logic [PW-1:0] seal_q
);
   initial assert (PW >= 1) else $error("protection width must be nonzero");

   for (genvar b = 0; b < PW; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            guard_q[b] <= 1'b0;
            seal_q[b]  <= 1'b0;
         end else begin
            if (guard_wr && !seal_q[b])
               guard_q[b] <= wdata[b];
            if (seal_wr && wdata[b])
               seal_q[b] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sigsel_mux.sv
module sigsel_mux #(
   parameter int unsigned DW = 32,
   parameter int unsigned NL = 8
) (
   input  logic [DW-1:0] sel,
   input  logic [DW-1:0] din,
   input  logic [NL-1:0] pat,
   output logic [DW-1:0] dout
);
   initial assert (NL >= 1 && NL <= DW) else $error("lane count out of range");

   for (genvar i = 0; i < DW; i++) begin : g_out
      localparam int unsigned LANE = i % NL;
      assign dout[i] = sel[i] ? pat[LANE] : din[i];
   end
endmodule

// File: rtl/sigsel_lockable.sv
module sigsel_lockable
   import sigsel_pkg::*;
#(
   parameter int unsigned AW = ADDR_W,
   parameter int unsigned DW = DATA_W,
   parameter int unsigned NL = LANES,
   parameter int unsigned PW = PROT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] data_in,
   input  logic [NL-1:0] pat_in,
   output logic [DW-1:0] sel_out
);
   localparam int unsigned PAD = DW - PW;
   initial assert (PW < DW) else $error("protection field wider than bus");

   wr_hit_t       hit;
   logic [DW-1:0] sel_q;
   logic [PW-1:0] guard_q;
   logic [PW-1:0] seal_q;

   sigsel_decode #(.AW(AW)) u_dec (
      .addr(bus_addr), .we(bus_we), .hit(hit)
   );

   sigsel_protect #(.PW(PW)) u_prot (
      .clk(clk), .rst_n(rst_n),
      .guard_wr(hit.guard), .seal_wr(hit.seal),
      .wdata(bus_wdata[PW-1:0]),
      .guard_q(guard_q), .seal_q(seal_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (hit.sel && !guard_q[0])
         sel_q <= bus_wdata;
   end

   sigsel_mux #(.DW(DW), .NL(NL)) u_mux (
      .sel(sel_q), .din(data_in), .pat(pat_in), .dout(sel_out)
   );

   always_comb begin
      if (bus_addr == OFF_SEL[AW-1:0])
         bus_rdata = sel_q;
      else if (bus_addr == OFF_GUARD[AW-1:0])
         bus_rdata = {{PAD{1'b0}}, guard_q};
      else if (bus_addr == OFF_SEAL[AW-1:0])
         bus_rdata = {{PAD{1'b0}}, seal_q};
      else
         bus_rdata = '0;
   end
endmodule

// File: rtl/sigsel_lockable_chk.sv
module sigsel_lockable_chk #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 32,
   parameter int unsigned NL = 8,
   parameter int unsigned PW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_we,
   input logic [DW-1:0] bus_rdata,
   input logic [DW-1:0] data_in,
   input logic [NL-1:0] pat_in,
   input logic [DW-1:0] sel_out,
   input logic [DW-1:0] sel_q,
   input logic [PW-1:0] guard_q,
   input logic [PW-1:0] seal_q
);
   logic [DW-1:0] expect_out;
   always_comb
      for (int i = 0; i < DW; i++)
         expect_out[i] = sel_q[i] ? pat_in[i % NL] : data_in[i];

   assert_mux_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_out == expect_out);

   assert_seal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seal_q[0] |=> seal_q[0]);

   assert_seal1_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      seal_q[1] |=> seal_q[1]);

   assert_guarded_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      guard_q[0] |=> $stable(sel_q));

   assert_sealed_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seal_q[0] |=> $stable(guard_q[0]));

   assert_sealed_guard1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seal_q[1] |=> $stable(guard_q[1]));

   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != 4'h0) |-> (bus_rdata[DW-1:PW] == '0));

   assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == 4'h0) |=> $stable(sel_q));
endmodule

bind sigsel_lockable sigsel_lockable_chk #(.AW(AW), .DW(DW), .NL(NL), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_rdata(bus_rdata), .data_in(data_in), .pat_in(pat_in),
   .sel_out(sel_out), .sel_q(sel_q), .guard_q(guard_q), .seal_q(seal_q)
);

// File: tb/sigsel_lockable_bench.sv
module sigsel_lockable_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] data_in = '0;
   logic [7:0]  pat_in = '0;
   logic [31:0] sel_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sigsel_lockable u_sigsel_lockable (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .data_in(data_in), .pat_in(pat_in), .sel_out(sel_out)
   );

   function automatic logic [31:0] model_out(logic [31:0] s, logic [31:0] d, logic [7:0] p);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = s[i] ? p[i % 8] : d[i];
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      data_in = 32'hA5C3_0F96; pat_in = 8'hFF; #1;
      rd(4'h0, v); check("R1 sel", v, 0);
      rd(4'hC, v); check("R1 guard", v, 0);
      rd(4'hE, v); check("R1 seal", v, 0);
      check("R1 out", sel_out, 32'hA5C3_0F96);
   endtask

   task automatic t_mux();
      logic [31:0] v;
      wr(4'h0, 32'h8040_2011);
      rd(4'h0, v); check("R3 sel load", v, 32'h8040_2011);
      data_in = 32'h1234_5678; pat_in = 8'b1000_0001; #1;
      check("R2 map a", sel_out, model_out(32'h8040_2011, 32'h1234_5678, 8'h81));
      pat_in = 8'h7E; data_in = 32'hFFFF_0000; #1;
      check("R2 map b", sel_out, model_out(32'h8040_2011, 32'hFFFF_0000, 8'h7E));
      wr(4'h0, 32'hFFFF_FFFF); pat_in = 8'h5A; #1;
      check("R2 all pat", sel_out, 32'h5A5A_5A5A);
   endtask

   task automatic t_guard();
      logic [31:0] v;
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, v); check("R4 guard rw", v, 32'h3);
      wr(4'h0, 32'h0000_1111);
      rd(4'h0, v); check("R3 guarded", v, 32'hFFFF_FFFF);
      wr(4'hC, 32'h0);
      rd(4'hC, v); check("R4 guard clr", v, 0);
      wr(4'h0, 32'h0000_1111);
      rd(4'h0, v); check("R3 unguarded", v, 32'h0000_1111);
   endtask

   task automatic t_reserved();
      logic [31:0] v;
      wr(4'h4, 32'hFFFF_FFFF);
      wr(4'hF, 32'hFFFF_FFFF);
      rd(4'h4, v); check("R8 rsvd read", v, 0);
      rd(4'h0, v); check("R8 sel kept", v, 32'h0000_1111);
      rd(4'hC, v); check("R8 guard kept", v, 0);
      rd(4'hE, v); check("R8 seal kept", v, 0);
   endtask

   task automatic t_seal();
      logic [31:0] v;
      wr(4'hE, 32'h0);
      rd(4'hE, v); check("R5 w0 noop", v, 0);
      wr(4'hC, 32'h1);
      wr(4'hE, 32'hFFFF_FFFD);
      rd(4'hE, v); check("R5 set bit0", v, 32'h1);
      wr(4'hC, 32'h2);
      rd(4'hC, v); check("R6 bit0 frozen bit1 free", v, 32'h3);
      wr(4'hE, 32'h0);
      rd(4'hE, v); check("R5 sticky", v, 32'h1);
      wr(4'h0, 32'hDEAD_BEEF);
      rd(4'h0, v); check("R9 read while locked", v, 32'h0000_1111);
      wr(4'hE, 32'h2);
      wr(4'hC, 32'h0);
      rd(4'hC, v); check("R6 both frozen", v, 32'h3);
      rd(4'hE, v); check("R9 seal read", v, 32'h3);
   endtask

   task automatic t_order();
      logic [31:0] v;
      do_reset();
      bus_addr = 4'hE; bus_wdata = 32'h1; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_addr = 4'hC; bus_wdata = 32'h1;
      @(posedge clk); #1;
      bus_we = 1'b0;
      rd(4'hC, v); check("R7 seal before guard", v, 0);
      do_reset();
      bus_addr = 4'hC; bus_wdata = 32'h1; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      bus_we = 1'b0;
      rd(4'h0, v); check("R7 guard before sel", v, 0);
      wr(4'hE, 32'h1); wr(4'hE, 32'h0);
      do_reset();
      rd(4'hE, v); check("R1 reset clears seal", v, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_reset();
      t_mux();
      t_guard();
      t_reserved();
      t_seal();
      t_order();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule